// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit condition and control byte of a small processor core and computes its next value every clock. The execution unit hands over the two operands, the result it produced and the kind of operation (add, subtract or bitwise logic), together with a mask that names which condition flags the instruction may touch. The block derives carry, half carry, overflow, negative and zero from those values. The sign flag is never stored on its own: it always follows negative xor overflow.

A command input covers the control side of the byte. It can set or clear the global interrupt enable, drop it when an interrupt is accepted, and raise it again on return from the handler. It can also store a selected bit of a register operand into the transfer flag T. A combinational output returns the register operand with T placed into the selected bit, which serves bit-load instructions. A full-byte write from the I/O space replaces the whole register and takes precedence over every other update made in the same cycle.

Top module: `sreg_flag_unit`

## Requirements
- R1: After reset `sreg_q` is 0. Its bit positions are: 7 interrupt enable I, 6 transfer T, 5 half carry H, 4 sign S, 3 overflow V, 2 negative N, 1 zero Z, 0 carry C.
- R2: S (bit 4) equals V xor N (bits 3 and 2) in every cycle, including right after an I/O write, where the written bit 4 is ignored.
- R3: For `alu_op`=0 (add), one cycle after the update the register holds: C = carry out of the top bit, H = carry out of bit 3, V = signed overflow of the sum, N = result top bit, Z = result is zero.
- R4: For `alu_op`=1 (subtract, result = a − b), the register holds: C = 1 when unsigned b exceeds a, H = 1 when b[3:0] exceeds a[3:0], V = signed overflow of the difference, and N and Z as for add.
- R5: For `alu_op`=2 (logic), V becomes 0, N and Z follow the result, and C and H keep their values whatever the mask says.
- R6: `alu_mask` bits {4:H, 3:V, 2:N, 1:Z, 0:C} enable the update of each flag. A flag whose mask bit is 0 keeps its value. Nothing is updated when `alu_valid` is 0 or `alu_op`=3.
- R7: `ctl_cmd`=1 sets I and `ctl_cmd`=2 clears I, effective the next cycle.
- R8: `ctl_cmd`=4 (interrupt accepted) clears I, and `ctl_cmd`=5 (return from interrupt) sets I.
- R9: `ctl_cmd`=3 copies bit `bit_sel` of `reg_in` into T.
- R10: `bld_out` equals `reg_in` with bit `bit_sel` replaced by the current T, in the same cycle and without a clock.
- R11: When `io_wr` is 1 the register takes `io_wdata` on the next edge, with S rebuilt per R2, and any ALU or command update in that cycle is discarded.
- R12: With no ALU update, `ctl_cmd` of 0 and no I/O write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_valid | input | 1 | An ALU flag update is presented this cycle |
| alu_op | input | 2 | 0 add, 1 subtract, 2 logic, 3 no flag effect |
| alu_a | input | 8 | First operand (minuend for subtract) |
| alu_b | input | 8 | Second operand (subtrahend for subtract) |
| alu_res | input | 8 | Result produced by the ALU |
| alu_mask | input | 5 | Per-flag update enable {H,V,N,Z,C} |
| ctl_cmd | input | 3 | 0 none, 1 set I, 2 clear I, 3 store bit to T, 4 interrupt accepted, 5 interrupt return |
| reg_in | input | 8 | Register operand for bit store and bit load |
| bit_sel | input | 3 | Bit index for bit store and bit load |
| io_wr | input | 1 | Full-byte write strobe |
| io_wdata | input | 8 | Byte written on `io_wr` |
| sreg_q | output | 8 | Status register |
| bld_out | output | 8 | `reg_in` with T inserted at `bit_sel` |

## Verification
The flag checks assume the ALU presents a consistent result: `alu_res` is the low byte of a+b for add and of a−b for subtract, because carry and overflow are derived from the sign and top bits of operands and result. The bench always computes `alu_res` from the operands it drives, so this assumption holds. The bench works out the expected flags with wide integer arithmetic, which shares no formula with the design. The checker's rules about I, C and H hold only when no I/O write occurs in the same cycle, and each of those properties excludes that case in its antecedent.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_LOGIC = 2'd2,
        ALU_NONE  = 2'd3
    } alu_op_e;

    typedef enum logic [2:0] {
        CTL_NONE     = 3'd0,
        CTL_SET_I    = 3'd1,
        CTL_CLR_I    = 3'd2,
        CTL_BSTORE   = 3'd3,
        CTL_INT_TAKE = 3'd4,
        CTL_INT_RET  = 3'd5,
        CTL_RSV6     = 3'd6,
        CTL_RSV7     = 3'd7
    } ctl_cmd_e;

    // Packed MSB first: i is bit 7, c is bit 0.
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    // Positions inside the update mask.
    localparam int MSK_C = 0;
    localparam int MSK_Z = 1;
    localparam int MSK_N = 2;
    localparam int MSK_V = 3;
    localparam int MSK_H = 4;
    localparam int MSK_W = 5;

endpackage

// File: rtl/sreg_arith_flags.sv
module sreg_arith_flags
    import sreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_i,
    output logic              c_o,
    output logic              h_o,
    output logic              v_o,
    output logic              n_o,
    output logic              z_o
);

    localparam int MSB = DATA_W - 1;
    localparam int HB  = DATA_W / 2 - 1;

    logic am, bm, rm, ah, bh, rh;

    always_comb begin
        am = a_i[MSB];
        bm = b_i[MSB];
        rm = res_i[MSB];
        ah = a_i[HB];
        bh = b_i[HB];
        rh = res_i[HB];

        n_o = rm;
        z_o = ~|res_i;
        c_o = 1'b0;
        h_o = 1'b0;
        v_o = 1'b0;

        unique case (op_i)
            ALU_ADD: begin
                c_o = (am & bm) | (bm & ~rm) | (~rm & am);
                h_o = (ah & bh) | (bh & ~rh) | (~rh & ah);
                v_o = (am & bm & ~rm) | (~am & ~bm & rm);
            end
            ALU_SUB: begin
                c_o = (~am & bm) | (bm & rm) | (rm & ~am);
                h_o = (~ah & bh) | (bh & rh) | (rh & ~ah);
                v_o = (am & ~bm & ~rm) | (~am & bm & rm);
            end
            ALU_LOGIC: begin
                v_o = 1'b0;
            end
            default: begin
                n_o = 1'b0;
                z_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sreg_bit_xfer.sv
module sreg_bit_xfer #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] reg_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              t_i,
    output logic              pick_o,
    output logic [DATA_W-1:0] ins_o
);

    assign pick_o = reg_i[sel_i];

    for (genvar g = 0; g < DATA_W; g++) begin : g_ins
        assign ins_o[g] = (sel_i == SEL_W'(g)) ? t_i : reg_i[g];
    end

endmodule

// File: rtl/sreg_flag_unit.sv
module sreg_flag_unit
    import sreg_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alu_valid,
    input  logic [1:0]          alu_op,
    input  logic [DATA_W-1:0]   alu_a,
    input  logic [DATA_W-1:0]   alu_b,
    input  logic [DATA_W-1:0]   alu_res,
    input  logic [MSK_W-1:0]    alu_mask,
    input  logic [2:0]          ctl_cmd,
    input  logic [DATA_W-1:0]   reg_in,
    input  logic [SEL_W-1:0]    bit_sel,
    input  logic                io_wr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          sreg_q,
    output logic [DATA_W-1:0]   bld_out
);

    alu_op_e  op;
    ctl_cmd_e cmd;
    sreg_t    st_d, st_q, wr_st;
    logic     f_c, f_h, f_v, f_n, f_z;
    logic     pick_bit;
    logic     arith_op;

    assign op       = alu_op_e'(alu_op);
    assign cmd      = ctl_cmd_e'(ctl_cmd);
    assign arith_op = (op == ALU_ADD) || (op == ALU_SUB);
    assign wr_st    = sreg_t'(io_wdata);

    sreg_arith_flags #(.DATA_W(DATA_W)) u_arith (
        .op_i  (op),
        .a_i   (alu_a),
        .b_i   (alu_b),
        .res_i (alu_res),
        .c_o   (f_c),
        .h_o   (f_h),
        .v_o   (f_v),
        .n_o   (f_n),
        .z_o   (f_z)
    );

    sreg_bit_xfer #(.DATA_W(DATA_W)) u_xfer (
        .reg_i  (reg_in),
        .sel_i  (bit_sel),
        .t_i    (st_q.t),
        .pick_o (pick_bit),
        .ins_o  (bld_out)
    );

    always_comb begin
        st_d = st_q;

        if (alu_valid && op != ALU_NONE) begin
            if (alu_mask[MSK_C] && arith_op) st_d.c = f_c;
            if (alu_mask[MSK_H] && arith_op) st_d.h = f_h;
            if (alu_mask[MSK_V])             st_d.v = f_v;
            if (alu_mask[MSK_N])             st_d.n = f_n;
            if (alu_mask[MSK_Z])             st_d.z = f_z;
        end

        unique case (cmd)
            CTL_SET_I:    st_d.i = 1'b1;
            CTL_CLR_I:    st_d.i = 1'b0;
            CTL_BSTORE:   st_d.t = pick_bit;
            CTL_INT_TAKE: st_d.i = 1'b0;
            CTL_INT_RET:  st_d.i = 1'b1;
            default:      ;
        endcase

        if (io_wr) begin
            st_d = wr_st;
        end

        st_d.s = st_d.n ^ st_d.v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sreg_q = st_q;

endmodule

// File: rtl/sreg_flag_unit_chk.sv
module sreg_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alu_valid,
    input logic [1:0] alu_op,
    input logic [2:0] ctl_cmd,
    input logic [2:0] bit_sel,
    input logic       io_wr,
    input logic [7:0] io_wdata,
    input logic [7:0] sreg_q,
    input logic [7:0] bld_out
);

    // R2
    s_follows_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sreg_q[4] == (sreg_q[3] ^ sreg_q[2]));

    // R11
    io_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> (sreg_q == {$past(io_wdata[7:5]),
                              $past(io_wdata[3]) ^ $past(io_wdata[2]),
                              $past(io_wdata[3:0])}));

    // R8
    int_take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_cmd == 3'd4 && !io_wr) |=> !sreg_q[7]);

    // R8
    int_ret_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_cmd == 3'd5 && !io_wr) |=> sreg_q[7]);

    // R5
    logic_keeps_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 2'd2 && !io_wr)
            |=> ($stable(sreg_q[0]) && $stable(sreg_q[5])));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_valid && ctl_cmd == 3'd0 && !io_wr) |=> $stable(sreg_q));

    // R10
    bit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bld_out[bit_sel] == sreg_q[6]);

endmodule

bind sreg_flag_unit sreg_flag_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .ctl_cmd   (ctl_cmd),
    .bit_sel   (bit_sel),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .sreg_q    (sreg_q),
    .bld_out   (bld_out)
);

// File: tb/sreg_flag_unit_tb.sv
module sreg_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_valid = 1'b0;
    logic [1:0] alu_op = 2'd3;
    logic [7:0] alu_a = '0;
    logic [7:0] alu_b = '0;
    logic [7:0] alu_res = '0;
    logic [4:0] alu_mask = '0;
    logic [2:0] ctl_cmd = '0;
    logic [7:0] reg_in = '0;
    logic [2:0] bit_sel = '0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] sreg_q;
    logic [7:0] bld_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = '0;

    always #10 clk = ~clk;

    sreg_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
        .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res), .alu_mask(alu_mask),
        .ctl_cmd(ctl_cmd), .reg_in(reg_in), .bit_sel(bit_sel), .io_wr(io_wr),
        .io_wdata(io_wdata), .sreg_q(sreg_q), .bld_out(bld_out)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alu_valid = 1'b0; alu_op = 2'd3; alu_mask = '0;
        ctl_cmd = '0; io_wr = 1'b0;
    endtask

    // One clock edge; returns 2 ns after it.
    task automatic cycle();
        @(posedge clk); #2;
    endtask

    function automatic logic [7:0] with_s(input logic [7:0] v);
        logic [7:0] r = v;
        r[4] = v[3] ^ v[2];
        return r;
    endfunction

    // Expected register after an ALU update, from the arithmetic definitions.
    function automatic logic [7:0] ref_alu(input logic [7:0] cur, input logic [1:0] op,
                                           input logic [7:0] a, input logic [7:0] b,
                                           input logic [7:0] r, input logic [4:0] m);
        logic [7:0] nx = cur;
        logic c = cur[0], h = cur[5], v = 1'b0;
        int sa = int'($signed(a));
        int sb = int'($signed(b));
        int s;
        if (op == 2'd0) begin
            c = (int'(a) + int'(b)) > 255;
            h = (int'(a[3:0]) + int'(b[3:0])) > 15;
            s = sa + sb;
            v = (s > 127) || (s < -128);
        end else if (op == 2'd1) begin
            c = b > a;
            h = b[3:0] > a[3:0];
            s = sa - sb;
            v = (s > 127) || (s < -128);
        end
        if (op == 2'd3) return cur;
        if (m[0]) nx[0] = c;
        if (m[4]) nx[5] = h;
        if (m[3]) nx[3] = v;
        if (m[2]) nx[2] = r[7];
        if (m[1]) nx[1] = (r == 8'h00);
        return with_s(nx);
    endfunction

    task automatic alu_step(input string req, input logic [1:0] op,
                            input logic [7:0] a, input logic [7:0] b, input logic [4:0] m);
        logic [7:0] r;
        r = (op == 2'd0) ? a + b : (op == 2'd1) ? a - b : (a & b);
        alu_valid = 1'b1; alu_op = op; alu_a = a; alu_b = b; alu_res = r; alu_mask = m;
        model = ref_alu(model, op, a, b, r, m);
        cycle();
        idle_inputs();
        check8(req, sreg_q, model);
    endtask

    task automatic ctl_step(input string req, input logic [2:0] cmd);
        ctl_cmd = cmd;
        case (cmd)
            3'd1, 3'd5: model[7] = 1'b1;
            3'd2, 3'd4: model[7] = 1'b0;
            3'd3:       model[6] = reg_in[bit_sel];
            default:    ;
        endcase
        cycle();
        idle_inputs();
        check8(req, sreg_q, model);
    endtask

    task automatic io_step(input string req, input logic [7:0] d);
        io_wr = 1'b1; io_wdata = d;
        model = with_s(d);
        cycle();
        idle_inputs();
        check8(req, sreg_q, model);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) cycle();
        check8("R1 reset value", sreg_q, 8'h00);
        rst_n = 1'b1;
        cycle();
        model = '0;
        check8("R1 after release", sreg_q, 8'h00);
    endtask

    task automatic t_add();
        alu_step("R3 add no flags",      2'd0, 8'h12, 8'h34, 5'h1F);
        alu_step("R3 add half carry",    2'd0, 8'h0F, 8'h01, 5'h1F);
        alu_step("R3 add overflow",      2'd0, 8'h7F, 8'h01, 5'h1F);
        alu_step("R3 add carry zero",    2'd0, 8'hFF, 8'h01, 5'h1F);
        alu_step("R3 add neg overflow",  2'd0, 8'h80, 8'h80, 5'h1F);
    endtask

    task automatic t_sub();
        alu_step("R4 sub borrow",        2'd1, 8'h00, 8'h01, 5'h1F);
        alu_step("R4 sub overflow",      2'd1, 8'h80, 8'h01, 5'h1F);
        alu_step("R4 sub equal zero",    2'd1, 8'h35, 8'h35, 5'h1F);
        alu_step("R4 sub pos overflow",  2'd1, 8'h7F, 8'hFF, 5'h1F);
    endtask

    task automatic t_logic();
        alu_step("R5 set C and H",       2'd0, 8'hFF, 8'hFF, 5'h1F);
        alu_step("R5 logic keeps C H",   2'd2, 8'hF0, 8'h0F, 5'h1F);
        alu_step("R5 logic sets N",      2'd2, 8'hF0, 8'h80, 5'h1F);
        alu_step("R5 V set again",       2'd0, 8'h7F, 8'h01, 5'h1F);
        alu_step("R5 logic clears V",    2'd2, 8'h11, 8'h01, 5'h1F);
    endtask

    task automatic t_mask();
        alu_step("R6 only Z",            2'd0, 8'hFF, 8'h01, 5'b00010);
        alu_step("R6 only C",            2'd1, 8'h00, 8'h01, 5'b00001);
        alu_step("R6 empty mask",        2'd0, 8'h7F, 8'h7F, 5'b00000);
        alu_step("R6 op 3 no effect",    2'd3, 8'h00, 8'h00, 5'h1F);
        alu_valid = 1'b0; alu_op = 2'd0; alu_a = 8'hFF; alu_b = 8'h01;
        alu_res = 8'h00; alu_mask = 5'h1F;
        cycle();
        idle_inputs();
        check8("R6 valid low", sreg_q, model);
    endtask

    task automatic t_irq();
        ctl_step("R7 set I",     3'd1);
        ctl_step("R7 clear I",   3'd2);
        ctl_step("R8 return",    3'd5);
        ctl_step("R8 accept",    3'd4);
        ctl_step("R7 reserved",  3'd6);
    endtask

    task automatic t_bits();
        for (int k = 0; k < 8; k++) begin
            reg_in = 8'h01 << k; bit_sel = 3'(k);
            ctl_step("R9 store one", 3'd3);
            #1;
            check8("R10 load one", bld_out, reg_in);
            reg_in = 8'h00;
            #1;
            check8("R10 load into zero", bld_out, 8'h01 << k);
            reg_in = ~(8'h01 << k);
            ctl_step("R9 store zero", 3'd3);
            reg_in = 8'hFF;
            #1;
            check8("R10 load zero", bld_out, ~(8'h01 << k));
        end
    endtask

    task automatic t_io();
        io_step("R11 plain write", 8'hA5);
        io_step("R2 inconsistent S", 8'h10);
        check8("R2 S is V xor N", {7'd0, sreg_q[4]}, {7'd0, sreg_q[3] ^ sreg_q[2]});
        // Write while ALU and command also request changes.
        alu_valid = 1'b1; alu_op = 2'd0; alu_a = 8'hFF; alu_b = 8'h01;
        alu_res = 8'h00; alu_mask = 5'h1F; ctl_cmd = 3'd1;
        io_step("R11 overrides all", 8'h48);
        cycle();
        check8("R12 idle hold", sreg_q, model);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_mask();
        t_irq();
        t_bits();
        t_io();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule